// File: doc/BRIEF.md
# Two-Output Prioritised Interrupt Controller

This block collects 32 level-type interrupt inputs and presents them to a processor on two request lines: a normal request and a fast request. Both lines see the same conditioned sources, but each keeps its own enable mask and its own priority threshold. Each one also reports which pending source should be serviced next. Before a source reaches either line, a per-source polarity bit can invert its input and a per-source sticky bit can make it hold a pulse until software acknowledges it.

Software reaches every register through a plain 32-bit read/write port with byte addresses. The two request banks start at 0x000 (normal) and 0x100 (fast). Within a bank, the offsets are: +0x00 masked status, +0x04 unmasked conditioned status, +0x08 enable-set (a read returns the mask), +0x0C enable-clear, +0x20 current source, +0x28 acknowledge, and +0x2C threshold. The shared registers are polarity at 0x200, sticky select at 0x204, and one 4-bit priority word per source at 0x300 + 4*n. Reading a bank's acknowledge location is a bus read with a side effect: it empties that bank's sticky latches.

Top module: `irq_dual_bank_ctrl`

## Requirements
- R1: After reset, both enable masks read 0 and both thresholds read 0xF. Polarity (0x200) reads 0xFFFFFFFF, sticky (0x204) reads 0, every priority word reads 0, and both request outputs are low.
- R2: A write to enable-set (+0x08) sets the mask bits where the data is 1. A write to enable-clear (+0x0C) clears the mask bits where the data is 1. Data bits of 0 leave the mask unchanged. Reading +0x08 returns the mask. The mask changes only on a bus write.
- R3: A polarity bit of 1 passes the source input unchanged and a 0 inverts it. The raw status at +0x04 shows the conditioned inputs before the enable mask is applied.
- R4: A source with its sticky bit set keeps its raw bit after its input goes inactive, until its bank's acknowledge location (+0x28) is read. That read affects only the bank that was read. A source with its sticky bit clear follows its input.
- R5: Status (+0x00) is raw status ANDed with the bank's enable mask and the threshold filter. The bank's request output is high exactly when status is nonzero.
- R6: A source passes the threshold when its priority value is less than or equal to the bank threshold. A threshold of 0xF passes every priority.
- R7: The current-source register (+0x20) gives the number of the status bit with the numerically lowest priority value. Ties go to the lower source number. It reads 0 when status is empty.
- R8: The two banks are independent. A source enabled only in one bank never raises the other bank's request.
- R9: Priority word n sits at 0x300 + 4*n. It stores the low 4 bits of the write data and reads them back zero-extended, without affecting other words.
- R10: When a sticky source is acknowledged while its input is still active, it stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 32 | Interrupt source inputs |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (side effects at the clock edge) |
| bus_addr_i | input | 12 | Register byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the same cycle as bus_rd_i |
| norm_req_o | output | 1 | Normal interrupt request |
| fast_req_o | output | 1 | Fast interrupt request |

## Verification
The hardest case to reach from the ports is a sticky source that is latched in both banks and then acknowledged in only one. The stimulus sets the sticky bit and enables the source in both banks. It then pulses the input for a single clock, reads one bank's acknowledge location, and checks that one request drops while the other stays high. A second variant holds the input high across the acknowledge read, to show that the source remains pending. Arbitration ties are created by giving two sources equal priority and removing the winner of a lower-valued priority.

// File: rtl/irq_dual_pkg.sv
// Package: shared sizes and register offsets for the two-output interrupt controller.
// Assumes a 32-bit register bus and one bit of bus data per source.
package irq_dual_pkg;
    localparam int NUM_SRC   = 32;
    localparam int PRIO_W    = 4;
    localparam int NUM_BANKS = 2;
    localparam int ADDR_W    = 12;

    // offsets inside one bank
    localparam logic [7:0] OFF_STATUS = 8'h00;
    localparam logic [7:0] OFF_RAW    = 8'h04;
    localparam logic [7:0] OFF_EN_SET = 8'h08;
    localparam logic [7:0] OFF_EN_CLR = 8'h0C;
    localparam logic [7:0] OFF_CUR    = 8'h20;
    localparam logic [7:0] OFF_ACK    = 8'h28;
    localparam logic [7:0] OFF_THR    = 8'h2C;

    // shared registers
    localparam logic [ADDR_W-1:0] ADR_POL    = 12'h200;
    localparam logic [ADDR_W-1:0] ADR_STICKY = 12'h204;
    localparam logic [3:0]        PAGE_PRIO  = 4'h3;
endpackage

// File: rtl/irq_prio_arbiter.sv
// Module: irq_prio_arbiter
// Picks the requesting source with the lowest priority value, with ties going to the lowest index.
// Assumes prio_flat_i holds N fields of PW bits, with field i at bits [i*PW +: PW].
module irq_prio_arbiter #(
    parameter int N  = 32,
    parameter int PW = 4,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]    req_i,
    input  logic [N*PW-1:0] prio_flat_i,
    output logic            any_o,
    output logic [IW-1:0]   win_o
);
    logic [PW-1:0] best;

    // linear scan; a strict compare keeps the earliest index on ties
    always_comb begin
        any_o = 1'b0;
        win_o = '0;
        best  = '1;
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && (!any_o || (prio_flat_i[i*PW +: PW] < best))) begin
                any_o = 1'b1;
                best  = prio_flat_i[i*PW +: PW];
                win_o = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_bank.sv
// Module: irq_bank
// One request bank: enable mask, threshold, sticky latches, filtered status and arbitration.
// Assumes level_i is already polarity-corrected, and that strobes last one cycle per bus access.
module irq_bank #(
    parameter int N  = 32,
    parameter int PW = 4,
    localparam int IW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    level_i,
    input  logic [N-1:0]    sticky_i,
    input  logic [N*PW-1:0] prio_flat_i,
    input  logic            en_set_we_i,
    input  logic            en_clr_we_i,
    input  logic            thr_we_i,
    input  logic            ack_rd_i,
    input  logic [N-1:0]    wdata_i,
    output logic [N-1:0]    en_o,
    output logic [PW-1:0]   thr_o,
    output logic [N-1:0]    latch_o,
    output logic [N-1:0]    raw_o,
    output logic [N-1:0]    status_o,
    output logic [IW-1:0]   cur_o,
    output logic            req_o
);
    logic [N-1:0] en_q;
    logic [N-1:0] latch_q;
    logic [N-1:0] thr_pass;
    logic [PW-1:0] thr_q;
    logic         any_w;

    // enable mask: set and clear with write-1 semantics
    always_ff @(posedge clk) begin
        if (!rst_n)          en_q <= '0;
        else if (en_set_we_i) en_q <= en_q | wdata_i;
        else if (en_clr_we_i) en_q <= en_q & ~wdata_i;
    end

    // threshold register, opens to all priorities at reset
    always_ff @(posedge clk) begin
        if (!rst_n)        thr_q <= '1;
        else if (thr_we_i) thr_q <= wdata_i[PW-1:0];
    end

    // sticky latches: capture active levels, emptied by an acknowledge read
    always_ff @(posedge clk) begin
        if (!rst_n)        latch_q <= '0;
        else if (ack_rd_i) latch_q <= '0;
        else               latch_q <= (latch_q | (level_i & sticky_i)) & sticky_i;
    end

    // per-source threshold comparison
    always_comb begin
        for (int i = 0; i < N; i++)
            thr_pass[i] = (prio_flat_i[i*PW +: PW] <= thr_q);
    end

    // raw and filtered status
    always_comb begin
        raw_o    = level_i | (latch_q & sticky_i);
        status_o = raw_o & en_q & thr_pass;
    end

    irq_prio_arbiter #(.N(N), .PW(PW)) arb_i (
        .req_i       (status_o),
        .prio_flat_i (prio_flat_i),
        .any_o       (any_w),
        .win_o       (cur_o)
    );

    assign en_o    = en_q;
    assign thr_o   = thr_q;
    assign latch_o = latch_q;
    assign req_o   = any_w;
endmodule

// File: rtl/irq_dual_bank_ctrl.sv
// Module: irq_dual_bank_ctrl
// Top: shared polarity/sticky/priority registers, address decode, read mux and two request banks.
// Assumes a single-cycle bus: a write lands at the clock edge, read data is combinational,
// and read side effects take place at the clock edge of the read cycle.
module irq_dual_bank_ctrl
    import irq_dual_pkg::*;
#(
    parameter int N  = NUM_SRC,
    parameter int PW = PRIO_W,
    parameter int AW = ADDR_W,
    localparam int IW = $clog2(N),
    localparam int DW = N,
    localparam int NB = NUM_BANKS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  src_i,
    input  logic          bus_wr_i,
    input  logic          bus_rd_i,
    input  logic [AW-1:0] bus_addr_i,
    input  logic [DW-1:0] bus_wdata_i,
    output logic [DW-1:0] bus_rdata_o,
    output logic          norm_req_o,
    output logic          fast_req_o
);
    logic [N-1:0]    pol_q;
    logic [N-1:0]    sticky_q;
    logic [PW-1:0]   prio_q [N];
    logic [N*PW-1:0] prio_flat;
    logic [N-1:0]    level;

    logic            bank_hit;
    logic [7:0]      bank_off;
    logic            prio_hit;
    logic [IW-1:0]   prio_idx;

    logic [N-1:0]    bank_en     [NB];
    logic [PW-1:0]   bank_thr    [NB];
    logic [N-1:0]    bank_latch  [NB];
    logic [N-1:0]    bank_raw    [NB];
    logic [N-1:0]    bank_status [NB];
    logic [IW-1:0]   bank_cur    [NB];
    logic            bank_req    [NB];
    logic            bank_ack    [NB];

    // address decode for banks and the priority page
    always_comb begin
        bank_hit = (bus_addr_i[AW-1:9] == '0);
        bank_off = bus_addr_i[7:0];
        prio_hit = (bus_addr_i[AW-1:8] == PAGE_PRIO) && (bus_addr_i[7] == 1'b0)
                   && (bus_addr_i[1:0] == 2'b00);
        prio_idx = bus_addr_i[IW+1:2];
    end

    // polarity and sticky selection registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q    <= '1;
            sticky_q <= '0;
        end else if (bus_wr_i) begin
            if (bus_addr_i == ADR_POL)    pol_q    <= bus_wdata_i;
            if (bus_addr_i == ADR_STICKY) sticky_q <= bus_wdata_i;
        end
    end

    // per-source priority words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) prio_q[i] <= '0;
        end else if (bus_wr_i && prio_hit) begin
            prio_q[prio_idx] <= bus_wdata_i[PW-1:0];
        end
    end

    // flatten priorities for the banks
    for (genvar g = 0; g < N; g++) begin : g_flat
        assign prio_flat[g*PW +: PW] = prio_q[g];
    end

    // polarity correction: a 1 keeps the input as is
    assign level = src_i ^ ~pol_q;

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic sel;
        assign sel         = bank_hit && (bus_addr_i[8] == b[0]);
        assign bank_ack[b] = bus_rd_i && sel && (bank_off == OFF_ACK);

        irq_bank #(.N(N), .PW(PW)) bank_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .level_i     (level),
            .sticky_i    (sticky_q),
            .prio_flat_i (prio_flat),
            .en_set_we_i (bus_wr_i && sel && (bank_off == OFF_EN_SET)),
            .en_clr_we_i (bus_wr_i && sel && (bank_off == OFF_EN_CLR)),
            .thr_we_i    (bus_wr_i && sel && (bank_off == OFF_THR)),
            .ack_rd_i    (bank_ack[b]),
            .wdata_i     (bus_wdata_i),
            .en_o        (bank_en[b]),
            .thr_o       (bank_thr[b]),
            .latch_o     (bank_latch[b]),
            .raw_o       (bank_raw[b]),
            .status_o    (bank_status[b]),
            .cur_o       (bank_cur[b]),
            .req_o       (bank_req[b])
        );
    end

    // read data multiplexer
    always_comb begin
        bus_rdata_o = '0;
        if (bank_hit) begin
            for (int b = 0; b < NB; b++) begin
                if (bus_addr_i[8] == b[0]) begin
                    case (bank_off)
                        OFF_STATUS: bus_rdata_o = bank_status[b];
                        OFF_RAW:    bus_rdata_o = bank_raw[b];
                        OFF_EN_SET: bus_rdata_o = bank_en[b];
                        OFF_CUR:    bus_rdata_o = DW'(bank_cur[b]);
                        OFF_ACK:    bus_rdata_o = DW'(bank_cur[b]);
                        OFF_THR:    bus_rdata_o = DW'(bank_thr[b]);
                        default:    bus_rdata_o = '0;
                    endcase
                end
            end
        end else if (bus_addr_i == ADR_POL) begin
            bus_rdata_o = pol_q;
        end else if (bus_addr_i == ADR_STICKY) begin
            bus_rdata_o = sticky_q;
        end else if (prio_hit) begin
            bus_rdata_o = DW'(prio_q[prio_idx]);
        end
    end

    assign norm_req_o = bank_req[0];
    assign fast_req_o = bank_req[1];
endmodule

// File: rtl/irq_dual_bank_chk.sv
// Module: irq_dual_bank_chk
// Concurrent checks on the controller, attached by bind to the top module.
// Assumes bank 0 is the normal bank and bank 1 is the fast bank.
module irq_dual_bank_chk #(
    parameter int N  = 32,
    parameter int PW = 4,
    localparam int IW = $clog2(N)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_wr,
    input logic            ack0,
    input logic [N-1:0]    en0,
    input logic [N-1:0]    en1,
    input logic [PW-1:0]   thr0,
    input logic [N-1:0]    latch0,
    input logic [N-1:0]    sticky,
    input logic [N-1:0]    status0,
    input logic [IW-1:0]   cur0,
    input logic [N*PW-1:0] prio_flat,
    input logic            fast_req
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (en0 == '0 && en1 == '0 && thr0 == '1));

    // R2
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(en0) && $stable(en1)));

    // R4
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack0 |=> ((latch0 & $past(latch0) & $past(sticky)) == ($past(latch0) & $past(sticky))));

    // R7
    winner_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|status0) |-> status0[cur0]);

    // R6
    winner_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|status0) |-> (prio_flat[cur0*PW +: PW] <= thr0));

    // R8
    fast_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en1 == '0) |-> !fast_req);
endmodule

bind irq_dual_bank_ctrl irq_dual_bank_chk #(.N(N), .PW(PW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr_i),
    .ack0      (bank_ack[0]),
    .en0       (bank_en[0]),
    .en1       (bank_en[1]),
    .thr0      (bank_thr[0]),
    .latch0    (bank_latch[0]),
    .sticky    (sticky_q),
    .status0   (bank_status[0]),
    .cur0      (bank_cur[0]),
    .prio_flat (prio_flat),
    .fast_req  (fast_req_o)
);

// File: tb/irq_dual_bank_ctrl_tb_top.sv
module irq_dual_bank_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        nreq;
    logic        freq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_dual_bank_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .src_i(src),
        .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .norm_req_o(nreq), .fast_req_o(freq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0; #1;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; rd = 1'b1; #2; d = rdata;
        @(negedge clk); rd = 1'b0; #1;
    endtask

    task automatic read_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_read(a, v);
        chk(tag, v, exp);
    endtask

    task automatic t_reset;
        chk("R1 norm_req", {31'b0, nreq}, 0);
        chk("R1 fast_req", {31'b0, freq}, 0);
        read_chk("R1 en0", 12'h008, 0);
        read_chk("R1 en1", 12'h108, 0);
        read_chk("R1 thr0", 12'h02C, 32'hF);
        read_chk("R1 thr1", 12'h12C, 32'hF);
        read_chk("R1 pol", 12'h200, 32'hFFFF_FFFF);
        read_chk("R1 sticky", 12'h204, 0);
        read_chk("R1 prio5", 12'h314, 0);
    endtask

    task automatic t_enable;
        bus_write(12'h008, 32'h0000_00F0);
        bus_write(12'h00C, 32'h0000_0030);
        read_chk("R2 mask after clear", 12'h008, 32'h0000_00C0);
        bus_write(12'h008, 32'h0000_0001);
        read_chk("R2 mask after set", 12'h008, 32'h0000_00C1);
        read_chk("R2 other bank", 12'h108, 0);
        bus_write(12'h00C, 32'hFFFF_FFFF);
    endtask

    task automatic t_polarity;
        read_chk("R3 raw idle", 12'h004, 0);
        bus_write(12'h200, ~32'h4);
        read_chk("R3 inverted raw", 12'h004, 32'h4);
        chk("R3 masked no req", {31'b0, nreq}, 0);
        bus_write(12'h008, 32'h4);
        chk("R5 req on", {31'b0, nreq}, 1);
        read_chk("R5 status", 12'h000, 32'h4);
        @(negedge clk); src[2] = 1'b1; #1;
        chk("R3 inverted active input", {31'b0, nreq}, 0);
        read_chk("R3 raw off", 12'h004, 0);
        src = '0;
        bus_write(12'h200, 32'hFFFF_FFFF);
        bus_write(12'h00C, 32'hFFFF_FFFF);
    endtask

    task automatic t_sticky;
        bus_write(12'h204, 32'h80);
        bus_write(12'h008, 32'h180);
        bus_write(12'h108, 32'h80);
        @(negedge clk); src[7] = 1'b1;
        @(negedge clk); src[7] = 1'b0; #1;
        chk("R4 norm held", {31'b0, nreq}, 1);
        chk("R4 fast held", {31'b0, freq}, 1);
        read_chk("R4 raw0 held", 12'h004, 32'h80);
        read_chk("R4 ack0", 12'h028, 32'd7);
        chk("R4 norm cleared", {31'b0, nreq}, 0);
        chk("R4 fast still set", {31'b0, freq}, 1);
        read_chk("R4 raw1 held", 12'h104, 32'h80);
        read_chk("R4 ack1", 12'h128, 32'd7);
        chk("R4 fast cleared", {31'b0, freq}, 0);
        // non-sticky source follows its level
        @(negedge clk); src[8] = 1'b1; #1;
        chk("R4 level high", {31'b0, nreq}, 1);
        @(negedge clk); src[8] = 1'b0; #1;
        chk("R4 level drop", {31'b0, nreq}, 0);
        // acknowledge while the input is still active
        @(negedge clk); src[7] = 1'b1;
        read_chk("R10 ack active", 12'h028, 32'd7);
        read_chk("R10 still pending", 12'h004, 32'h80);
        chk("R10 req", {31'b0, nreq}, 1);
        @(negedge clk); src[7] = 1'b0; #1;
        chk("R10 relatched", {31'b0, nreq}, 1);
        read_chk("R10 ack", 12'h028, 32'd7);
        chk("R10 cleared", {31'b0, nreq}, 0);
        bus_write(12'h204, 0);
        bus_write(12'h00C, 32'hFFFF_FFFF);
        bus_write(12'h10C, 32'hFFFF_FFFF);
    endtask

    task automatic t_threshold;
        bus_write(12'h30C, 32'd5);
        bus_write(12'h008, 32'h8);
        @(negedge clk); src[3] = 1'b1; #1;
        bus_write(12'h02C, 32'd5);
        chk("R6 equal passes", {31'b0, nreq}, 1);
        bus_write(12'h02C, 32'd4);
        chk("R6 blocked", {31'b0, nreq}, 0);
        read_chk("R5 status blocked", 12'h000, 0);
        read_chk("R5 raw unaffected", 12'h004, 32'h8);
        bus_write(12'h02C, 32'hF);
        chk("R6 open", {31'b0, nreq}, 1);
        src = '0;
        bus_write(12'h30C, 0);
        bus_write(12'h00C, 32'hFFFF_FFFF);
    endtask

    task automatic t_arbit;
        bus_write(12'h328, 32'd2);
        bus_write(12'h350, 32'd1);
        bus_write(12'h310, 32'd2);
        bus_write(12'h108, 32'h0010_0410);
        @(negedge clk); src = 32'h0010_0410; #1;
        read_chk("R7 lowest value wins", 12'h120, 32'd20);
        chk("R8 norm idle", {31'b0, nreq}, 0);
        chk("R8 fast active", {31'b0, freq}, 1);
        @(negedge clk); src[20] = 1'b0; #1;
        read_chk("R7 tie lowest index", 12'h120, 32'd4);
        bus_write(12'h310, 32'd3);
        read_chk("R7 reorder", 12'h120, 32'd10);
        @(negedge clk); src = '0; #1;
        read_chk("R7 empty", 12'h120, 0);
        chk("R5 fast idle", {31'b0, freq}, 0);
        bus_write(12'h328, 0);
        bus_write(12'h350, 0);
        bus_write(12'h310, 0);
        bus_write(12'h10C, 32'hFFFF_FFFF);
    endtask

    task automatic t_prio_rw;
        bus_write(12'h37C, 32'hFFFF_FFFA);
        read_chk("R9 word31", 12'h37C, 32'hA);
        read_chk("R9 word0", 12'h300, 0);
        read_chk("R9 word30", 12'h378, 0);
        bus_write(12'h37C, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_enable();
        t_polarity();
        t_sticky();
        t_threshold();
        t_arbit();
        t_prio_rw();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule